// File: doc/BRIEF.md
# Windowed Multirate FIR Engine

This block runs a finite impulse response filter over one window of samples for each start command. It works at an integer rate ratio in one of two directions. In the first, it reduces the rate by M and computes only every M-th result. In the second, it raises the rate by L: a zero-stuffed sequence, with L-1 zeros placed after each input, is filtered. A ratio of one gives plain single-rate filtering. The coefficient store and the sample buffer sit outside the block and are read through two address/data ports with an asynchronous read. Each result leaves through a valid/ready stream, and a one-cycle done pulse closes the run.

When start is seen, the tap count, window length, ratio and up-sample flag are captured and checked against the rules for a legal setup. A setup that breaks a rule ends the run at once with done and the error flag, and no result is produced. A legal setup runs a multiply-accumulate of one tap per clock into a wide accumulator. The sum is rounded and saturated to the output width and then offered on the stream. In up-sample mode the engine walks only the taps that meet real samples, so the inserted zeros cost no cycles.

Top module: `fir_mr_engine`

## Requirements
- R1: After reset, out_valid, done and err are all low until a start is accepted.
- R2: With cfg_upsamp=0 and cfg_ratio=1, a run produces cfg_win results; result k is the sum over j<N of coef[j]*samp[N-1+k-j], where N is cfg_taps.
- R3: With cfg_upsamp=0 and cfg_ratio=M, result k is the sum over j<N of coef[j]*samp[N-1+k*M-j]; the sample buffer is read only at addresses below N-1+W*M, where W is cfg_win.
- R4: With cfg_upsamp=1 and cfg_ratio=L, result i (0<=i<W) is the sum of coef[j]*samp[(i-j)/L] over all j<N with i-j>=0 and (i-j) divisible by L; earlier history is zero and only addresses below W/L are read.
- R5: Each result is floor((acc + 2^14) / 2^15), i.e. the Q15 product sum is rounded half up.
- R6: A rounded value above 32767 gives 32767, and one below -32768 gives -32768.
- R7: A start with cfg_taps=0, cfg_taps>1024, cfg_win=0 or cfg_ratio=0 is an error.
- R8: A start with cfg_upsamp=0 and cfg_taps smaller than cfg_ratio is an error.
- R9: A start with cfg_upsamp=1, cfg_ratio>1 and cfg_win not a whole multiple of cfg_ratio is an error.
- R10: An error run raises done with err high and produces no result; err is never high without done.
- R11: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value; stalls do not change any result.
- R12: done is a single-cycle pulse after the last result is accepted, and it never coincides with out_valid.
- R13: A start that arrives while a run is in progress, including in the cycle its last result is accepted, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run with the current configuration |
| cfg_taps | input | TW (11) | Tap count N |
| cfg_win | input | WW (12) | Window length in results |
| cfg_ratio | input | RW (8) | Rate ratio M or L |
| cfg_upsamp | input | 1 | 1 = raise the rate, 0 = reduce or keep the rate |
| coef_addr | output | TW (11) | Coefficient read address |
| coef_data | input | CW (16) | Coefficient read data, signed Q15 |
| samp_addr | output | SAW (20) | Sample buffer read address |
| samp_data | input | DW (16) | Sample read data, signed |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | DW (16) | Rounded, saturated result |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Configuration error, valid with done |

## Verification
The sharp overlap is a new start in the same cycle in which the final result of a run is handed over. The bench holds out_ready high, counts valid results and raises start exactly in the cycle that carries the last handshake. It then requires exactly one done, no error and no extra result in the scoreboard. A second case raises start in the middle of a stalled run with a setup that would be an error. It is judged the same way: the first run's results and its clean done must arrive untouched.

// File: rtl/fir_mr_pkg.sv
package fir_mr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_MAC,
    ST_OUT,
    ST_FIN
  } seq_state_t;

endpackage

// File: rtl/fir_mr_cfg_check.sv
// Static legality of a captured setup; the divisibility test for
// up-sampling is done iteratively by the sequencer.
module fir_mr_cfg_check #(
  parameter int TW       = 11,
  parameter int WW       = 12,
  parameter int RW       = 8,
  parameter int MAX_TAPS = 1024
) (
  input  logic [TW-1:0] taps,
  input  logic [WW-1:0] win,
  input  logic [RW-1:0] ratio,
  input  logic          upsamp,
  output logic          static_ok,
  output logic          need_div
);

  localparam int CW_MAX = (TW > RW) ? TW : RW;

  logic taps_ok;
  logic field_ok;
  logic ratio_fit;

  always_comb begin
    taps_ok   = (taps != '0) && (taps <= TW'(MAX_TAPS));
    field_ok  = (win != '0) && (ratio != '0);
    ratio_fit = upsamp || (CW_MAX'(ratio) <= CW_MAX'(taps));
    static_ok = taps_ok && field_ok && ratio_fit;
    need_div  = upsamp && (ratio > RW'(1));
  end

endmodule

// File: rtl/fir_mr_mac.sv
// One-tap-per-clock accumulator with round-half-up and saturation.
module fir_mr_mac #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int AW   = 40,
  parameter int FRAC = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [CW-1:0] coef,
  input  logic signed [DW-1:0] samp,
  output logic signed [DW-1:0] result
);

  localparam int PW = CW + DW;
  localparam logic signed [AW-1:0] RND_BIAS = AW'(1) <<< (FRAC - 1);
  localparam logic signed [AW-1:0] SAT_HI   = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] SAT_LO   = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] acc_q, acc_d;
  logic signed [AW-1:0] rounded;
  logic signed [AW-1:0] scaled;

  always_comb begin
    prod  = coef * samp;
    acc_d = acc_q;
    if (clr)
      acc_d = '0;
    else if (en)
      acc_d = acc_q + {{(AW-PW){prod[PW-1]}}, prod};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc_q <= '0;
    else
      acc_q <= acc_d;
  end

  always_comb begin
    rounded = acc_q + RND_BIAS;
    scaled  = rounded >>> FRAC;
    if (scaled > SAT_HI)
      result = SAT_HI[DW-1:0];
    else if (scaled < SAT_LO)
      result = SAT_LO[DW-1:0];
    else
      result = scaled[DW-1:0];
  end

endmodule

// File: rtl/fir_mr_seq.sv
// Run control: setup capture, divisibility test, tap/address walk,
// output handshake and end-of-run pulse.
module fir_mr_seq
  import fir_mr_pkg::*;
#(
  parameter int TW  = 11,
  parameter int WW  = 12,
  parameter int RW  = 8,
  parameter int SAW = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [TW-1:0]  cfg_taps,
  input  logic [WW-1:0]  cfg_win,
  input  logic [RW-1:0]  cfg_ratio,
  input  logic           cfg_upsamp,
  input  logic           static_ok,
  input  logic           need_div,
  input  logic           out_ready,
  output logic [TW-1:0]  coef_addr,
  output logic [SAW-1:0] samp_addr,
  output logic           mac_clr,
  output logic           mac_en,
  output logic           out_valid,
  output logic           done,
  output logic           err
);

  localparam int SW = ((TW > RW) ? TW : RW) + 1;

  seq_state_t     st_q, st_d;
  logic [TW-1:0]  taps_q, taps_d;
  logic [WW-1:0]  win_q, win_d;
  logic [RW-1:0]  ratio_q, ratio_d;
  logic           up_q, up_d;
  logic [WW-1:0]  rem_q, rem_d;
  logic [TW-1:0]  j_q, j_d;
  logic [SAW-1:0] a_q, a_d;
  logic [SAW-1:0] ptr_q, ptr_d;
  logic [RW-1:0]  ph_q, ph_d;
  logic [WW-1:0]  k_q, k_d;
  logic           err_q, err_d;

  logic [SW-1:0]  step;
  logic [SW-1:0]  j_next;
  logic           last_tap;

  always_comb begin
    step     = up_q ? SW'(ratio_q) : SW'(1);
    j_next   = SW'(j_q) + step;
    last_tap = (j_next >= SW'(taps_q)) || (a_q == '0);
  end

  always_comb begin
    st_d    = st_q;
    taps_d  = taps_q;
    win_d   = win_q;
    ratio_d = ratio_q;
    up_d    = up_q;
    rem_d   = rem_q;
    j_d     = j_q;
    a_d     = a_q;
    ptr_d   = ptr_q;
    ph_d    = ph_q;
    k_d     = k_q;
    err_d   = err_q;
    mac_clr = 1'b0;
    mac_en  = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          taps_d  = cfg_taps;
          win_d   = cfg_win;
          ratio_d = cfg_ratio;
          up_d    = cfg_upsamp;
          rem_d   = cfg_win;
          k_d     = '0;
          j_d     = '0;
          ph_d    = '0;
          err_d   = 1'b0;
          mac_clr = 1'b1;
          if (cfg_upsamp) begin
            a_d   = '0;
            ptr_d = '0;
          end else begin
            a_d   = SAW'(cfg_taps) - SAW'(1);
            ptr_d = SAW'(cfg_taps) - SAW'(1);
          end
          if (!static_ok) begin
            err_d = 1'b1;
            st_d  = ST_FIN;
          end else if (need_div) begin
            st_d = ST_CHECK;
          end else begin
            st_d = ST_MAC;
          end
        end
      end

      ST_CHECK: begin
        if (rem_q < WW'(ratio_q)) begin
          if (rem_q == '0) begin
            st_d = ST_MAC;
          end else begin
            err_d = 1'b1;
            st_d  = ST_FIN;
          end
        end else begin
          rem_d = rem_q - WW'(ratio_q);
        end
      end

      ST_MAC: begin
        mac_en = (j_q < taps_q);
        if (last_tap) begin
          st_d = ST_OUT;
        end else begin
          j_d = j_next[TW-1:0];
          a_d = a_q - SAW'(1);
        end
      end

      ST_OUT: begin
        if (out_ready) begin
          if (k_q == win_q - WW'(1)) begin
            st_d = ST_FIN;
          end else begin
            k_d     = k_q + WW'(1);
            mac_clr = 1'b1;
            st_d    = ST_MAC;
            if (up_q) begin
              if (ph_q == ratio_q - RW'(1)) begin
                ph_d  = '0;
                ptr_d = ptr_q + SAW'(1);
              end else begin
                ph_d  = ph_q + RW'(1);
              end
              j_d = TW'(ph_d);
              a_d = ptr_d;
            end else begin
              ptr_d = ptr_q + SAW'(ratio_q);
              j_d   = '0;
              a_d   = ptr_d;
            end
          end
        end
      end

      ST_FIN: begin
        st_d = ST_IDLE;
      end

      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      taps_q  <= '0;
      win_q   <= '0;
      ratio_q <= '0;
      up_q    <= 1'b0;
      rem_q   <= '0;
      j_q     <= '0;
      a_q     <= '0;
      ptr_q   <= '0;
      ph_q    <= '0;
      k_q     <= '0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      taps_q  <= taps_d;
      win_q   <= win_d;
      ratio_q <= ratio_d;
      up_q    <= up_d;
      rem_q   <= rem_d;
      j_q     <= j_d;
      a_q     <= a_d;
      ptr_q   <= ptr_d;
      ph_q    <= ph_d;
      k_q     <= k_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    coef_addr = j_q;
    samp_addr = a_q;
    out_valid = (st_q == ST_OUT);
    done      = (st_q == ST_FIN);
    err       = (st_q == ST_FIN) && err_q;
  end

endmodule

// File: rtl/fir_mr_engine.sv
module fir_mr_engine #(
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int AW       = 40,
  parameter int FRAC     = 15,
  parameter int TW       = 11,
  parameter int WW       = 12,
  parameter int RW       = 8,
  parameter int SAW      = 20,
  parameter int MAX_TAPS = 1024
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [TW-1:0]  cfg_taps,
  input  logic [WW-1:0]  cfg_win,
  input  logic [RW-1:0]  cfg_ratio,
  input  logic           cfg_upsamp,
  output logic [TW-1:0]  coef_addr,
  input  logic [CW-1:0]  coef_data,
  output logic [SAW-1:0] samp_addr,
  input  logic [DW-1:0]  samp_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_data,
  output logic           done,
  output logic           err
);

  logic [1:0] rst_pipe;
  logic       rst_int_n;
  logic       static_ok;
  logic       need_div;
  logic       mac_clr;
  logic       mac_en;
  logic signed [DW-1:0] mac_res;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= 2'b00;
    else
      rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  fir_mr_cfg_check #(
    .TW(TW), .WW(WW), .RW(RW), .MAX_TAPS(MAX_TAPS)
  ) u_chk (
    .taps      (cfg_taps),
    .win       (cfg_win),
    .ratio     (cfg_ratio),
    .upsamp    (cfg_upsamp),
    .static_ok (static_ok),
    .need_div  (need_div)
  );

  fir_mr_seq #(
    .TW(TW), .WW(WW), .RW(RW), .SAW(SAW)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .cfg_taps   (cfg_taps),
    .cfg_win    (cfg_win),
    .cfg_ratio  (cfg_ratio),
    .cfg_upsamp (cfg_upsamp),
    .static_ok  (static_ok),
    .need_div   (need_div),
    .out_ready  (out_ready),
    .coef_addr  (coef_addr),
    .samp_addr  (samp_addr),
    .mac_clr    (mac_clr),
    .mac_en     (mac_en),
    .out_valid  (out_valid),
    .done       (done),
    .err        (err)
  );

  fir_mr_mac #(
    .DW(DW), .CW(CW), .AW(AW), .FRAC(FRAC)
  ) u_mac (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (mac_clr),
    .en     (mac_en),
    .coef   (coef_data),
    .samp   (samp_data),
    .result (mac_res)
  );

  assign out_data = mac_res;

endmodule

// File: rtl/fir_mr_engine_chk.sv
module fir_mr_engine_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          done,
  input logic          err
);

  logic [15:0] hs_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hs_cnt <= '0;
    else if (done)
      hs_cnt <= '0;
    else if (out_valid && out_ready)
      hs_cnt <= hs_cnt + 16'd1;
  end

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R11
  hs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid);

  // R12
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R10
  err_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && err |-> hs_cnt == 16'd0);

endmodule

bind fir_mr_engine fir_mr_engine_chk #(.DW(DW)) u_engine_chk (.*);

// File: tb/fir_mr_engine_test.sv
module fir_mr_engine_test;

  localparam int DW = 16, CW = 16, TW = 11, WW = 12, RW = 8, SAW = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [TW-1:0]  cfg_taps = '0;
  logic [WW-1:0]  cfg_win = '0;
  logic [RW-1:0]  cfg_ratio = '0;
  logic           cfg_upsamp = 1'b0;
  logic [TW-1:0]  coef_addr;
  logic [CW-1:0]  coef_data;
  logic [SAW-1:0] samp_addr;
  logic [DW-1:0]  samp_data;
  logic           out_valid;
  logic           out_ready = 1'b0;
  logic [DW-1:0]  out_data;
  logic           done;
  logic           err;

  logic signed [15:0] coef_mem [0:2047];
  logic signed [15:0] samp_mem [0:1023];
  assign coef_data = coef_mem[coef_addr];
  assign samp_data = samp_mem[samp_addr];

  always #4 clk = ~clk;

  fir_mr_engine #(.SAW(SAW)) uut (.*);

  int n_chk = 0, n_bad = 0;
  int done_cnt = 0;
  logic last_err = 1'b0;
  string cur_req = "R2";
  logic signed [15:0] exp_q [$];
  int rdy_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  logic pv = 1'b0, pr = 1'b0;
  logic [15:0] pd = '0;
  logic mon_on = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic signed [15:0] rnd_sat(input longint acc);
    longint t;
    t = (acc + 16384) >>> 15;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return 16'(t);
  endfunction

  // ready pattern, driven away from the clock edge
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= (rdy_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[2]);
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (pv && !pr)
        chk(out_valid && out_data == pd, "R11", longint'($signed(out_data)), longint'($signed(pd)));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0)
          chk(1'b0, {cur_req, " extra result"}, longint'($signed(out_data)), 0);
        else begin
          logic signed [15:0] e;
          e = exp_q.pop_front();
          chk($signed(out_data) == e, cur_req, longint'($signed(out_data)), longint'(e));
        end
      end
      if (done) begin
        done_cnt++;
        last_err = err;
      end
      pv = out_valid;
      pr = out_ready;
      pd = out_data;
    end
  end

  task automatic expect_run(input int n, input int w, input int r, input bit up);
    for (int i = 0; i < w; i++) begin
      longint acc = 0;
      for (int j = 0; j < n; j++) begin
        if (!up) acc += longint'(coef_mem[j]) * longint'(samp_mem[n - 1 + i * r - j]);
        else if ((i - j) >= 0 && ((i - j) % r) == 0)
          acc += longint'(coef_mem[j]) * longint'(samp_mem[(i - j) / r]);
      end
      exp_q.push_back(rnd_sat(acc));
    end
  endtask

  task automatic pulse_start(input int n, input int w, input int r, input bit up);
    @(posedge clk); #1;
    cfg_taps = TW'(n); cfg_win = WW'(w); cfg_ratio = RW'(r); cfg_upsamp = up;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    while (done_cnt == d0) @(negedge clk);
  endtask

  task automatic run(input int n, input int w, input int r, input bit up,
                     input bit exp_err, input string req);
    int d0;
    cur_req = req;
    if (!exp_err) expect_run(n, w, r, up);
    d0 = done_cnt;
    pulse_start(n, w, r, up);
    wait_done(d0);
    chk(last_err == exp_err, {req, " err flag"}, longint'(last_err), longint'(exp_err));
    chk(exp_q.size() == 0, {req, " missing results"}, exp_q.size(), 0);
    exp_q.delete();
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int d0, seen;
    for (int i = 0; i < 2048; i++) coef_mem[i] = 16'(((i * 53 + 7) % 61 - 30) * 311);
    for (int i = 0; i < 1024; i++) samp_mem[i] = 16'(((i * 37 + 11) % 201 - 100) * 97);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1
    chk(!out_valid && !done && !err, "R1", {out_valid, done, err}, 0);
    mon_on = 1'b1;

    run(5, 6, 1, 1'b0, 1'b0, "R2");
    rdy_mode = 1;
    run(7, 5, 3, 1'b0, 1'b0, "R3");
    run(4, 4, 4, 1'b0, 1'b0, "R3");
    run(8, 9, 3, 1'b1, 1'b0, "R4");
    run(3, 8, 4, 1'b1, 1'b0, "R4");
    rdy_mode = 0;

    // R5 rounding: single tap of 1
    coef_mem[0] = 16'sd1;
    samp_mem[0] = 16'sd16384; samp_mem[1] = -16'sd16384;
    samp_mem[2] = 16'sd16383; samp_mem[3] = -16'sd16385;
    run(1, 4, 1, 1'b0, 1'b0, "R5");

    // R6 saturation both ways
    for (int i = 0; i < 4; i++) coef_mem[i] = 16'sd32767;
    for (int i = 0; i < 4; i++) samp_mem[i] = 16'sd32767;
    for (int i = 4; i < 8; i++) samp_mem[i] = -16'sd32768;
    run(4, 5, 1, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 2048; i++) coef_mem[i] = 16'(((i * 53 + 7) % 61 - 30) * 311);
    for (int i = 0; i < 1024; i++) samp_mem[i] = 16'(((i * 37 + 11) % 201 - 100) * 97);

    run(0, 4, 1, 1'b0, 1'b1, "R7");
    run(1025, 4, 1, 1'b0, 1'b1, "R7");
    run(4, 0, 1, 1'b0, 1'b1, "R7");
    run(4, 4, 0, 1'b0, 1'b1, "R7");
    run(3, 4, 4, 1'b0, 1'b1, "R8");
    run(6, 10, 3, 1'b1, 1'b1, "R9");
    run(6, 12, 3, 1'b1, 1'b0, "R9");

    // R13: start mid-run with a would-be error setup
    rdy_mode = 1;
    cur_req = "R13";
    expect_run(6, 6, 2, 1'b0);
    d0 = done_cnt;
    pulse_start(6, 6, 2, 1'b0);
    repeat (5) @(posedge clk);
    pulse_start(0, 0, 0, 1'b0);
    wait_done(d0);
    chk(last_err == 1'b0, "R13 err flag", longint'(last_err), 0);
    chk(exp_q.size() == 0, "R13 missing results", exp_q.size(), 0);
    exp_q.delete();
    repeat (3) @(posedge clk);

    // R13: start in the cycle of the final handshake
    rdy_mode = 0;
    repeat (2) @(posedge clk);
    cur_req = "R13";
    expect_run(5, 4, 1, 1'b0);
    d0 = done_cnt;
    pulse_start(5, 4, 1, 1'b0);
    seen = 0;
    while (seen < 4) begin
      @(posedge clk); #1;
      if (out_valid) seen++;
    end
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    wait_done(d0);
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(done_cnt == d0 + 1, "R13 done count", done_cnt - d0, 1);
    chk(exp_q.size() == 0 && !out_valid, "R13 extra run", exp_q.size(), 0);
    chk(last_err == 1'b0, "R12 clean done", longint'(last_err), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule